// File: doc/BRIEF.md
# Clear Channel Assessment Controller

This block tells a host whether the radio channel may be used for transmission. Each cycle in which the sample strobe is high, it takes one received-strength sample and two signal-quality measures. It compares each of them with its own programmable threshold. The strength comparison gives an energy flag. The two quality comparisons together give a carrier flag. A four-state machine turns these flags into a clear/busy decision.

When energy is present without a carrier, the channel is reported busy only for a bounded time. This time is measured by an inner counter of M samples nested inside an outer counter of N wraps. After M×N such samples the block declares the channel clear, so that a steady interferer cannot lock the transmitter out for good. The decision is advisory only. It appears on one pin whose polarity is chosen by a configuration bit. The latest strength sample is held on a read port for the host.

Top module: `cca_ctrl`

## Requirements
- R1: After reset is released, the decision is CLEAR, both timeout counters are zero and the strength read port `rssi_rd` reads 0.
- R2: The energy flag of a sample is set only when `rssi_smp` is strictly greater than `ed_thr`. Equal values do not set it.
- R3: The carrier flag of a sample is set only when `qual_a >= qa_thr` and also `qual_b >= qb_thr`.
- R4: A sample with neither flag makes the decision CLEAR and returns the timeout count to zero.
- R5: A sample with the carrier flag makes the decision BUSY and returns the timeout count to zero, whatever the energy flag is.
- R6: A sample with energy but no carrier advances the timeout count and gives BUSY. The M'×N'-th such sample in a row, counted since the last reset of the count, gives CLEAR instead and resets the count. M' and N' are the effective limits defined in R8.
- R7: Once the timeout has expired, further energy-only samples keep the decision CLEAR. It changes only after a sample with the carrier flag or a sample with neither flag.
- R8: A limit value of zero on `inner_lim` (M) or `outer_lim` (N) acts as one. The effective limits are M' and N'.
- R9: `cca_out` is 1 for CLEAR and 0 for BUSY when `pol_low` is 0. Both levels are inverted when `pol_low` is 1. A change of `pol_low` reaches the pin in the same cycle.
- R10: A cycle with `smp_vld` low changes neither the decision, nor the counters, nor `rssi_rd`. A cycle with `smp_vld` high loads `rssi_smp` into `rssi_rd`.
- R11: A sample presented with `smp_vld` high is reflected on `cca_out` and `rssi_rd` right after the next rising clock edge. Before that edge both keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld | input | 1 | Marks a new sample on the data inputs |
| rssi_smp | input | 8 | Received-strength sample, unsigned |
| qual_a | input | 8 | First signal-quality measure, unsigned |
| qual_b | input | 8 | Second signal-quality measure, unsigned |
| ed_thr | input | 8 | Energy threshold |
| qa_thr | input | 8 | Threshold for `qual_a` |
| qb_thr | input | 8 | Threshold for `qual_b` |
| inner_lim | input | 8 | Inner timeout count M (0 acts as 1) |
| outer_lim | input | 8 | Outer timeout count N (0 acts as 1) |
| pol_low | input | 1 | 1 selects active-low polarity for the clear level |
| cca_out | output | 1 | Clear/busy decision |
| rssi_rd | output | 8 | Last sampled strength, for the host to read |

## Verification
The assertions check, on every cycle, the transitions that one sample alone decides. A carrier sample leads to BUSY, and a sample with neither flag leads to CLEAR. Both counters are zero after any clearing sample. Cycles without a sample leave the state, the counters and the held strength unchanged. An expired timeout stays expired under energy-only samples.

Only the bench's sample sequences can show the long-range behaviour. This covers the exact count of M'×N' energy-only samples before the channel is declared clear, the effect of zero limits, and how the count restarts when a carrier or idle sample is mixed into a run. It also covers the same-cycle effect of the polarity bit and the strict and inclusive threshold edges.

// File: rtl/cca_pkg.sv
package cca_pkg;

  // Decision states of the assessment machine
  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,  // no energy, no carrier
    ST_CS    = 2'd1,  // carrier present
    ST_ED    = 2'd2,  // energy only, timeout running
    ST_EXP   = 2'd3   // energy only, timeout expired
  } cca_st_e;

  function automatic logic st_is_clear(cca_st_e s);
    return (s == ST_CLEAR) || (s == ST_EXP);
  endfunction

endpackage

// File: rtl/cca_detect.sv
module cca_detect #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] rssi_smp,
  input  logic [DW-1:0] qual_a,
  input  logic [DW-1:0] qual_b,
  input  logic [DW-1:0] ed_thr,
  input  logic [DW-1:0] qa_thr,
  input  logic [DW-1:0] qb_thr,
  output logic          ed_flag,
  output logic          cs_flag,
  output logic [DW-1:0] rssi_q
);

  localparam int NQ = 2;

  logic [NQ-1:0]  q_meet;
  logic [DW-1:0]  q_val [NQ];
  logic [DW-1:0]  q_thr [NQ];
  logic [DW-1:0]  rssi_d;

  assign q_val[0] = qual_a;
  assign q_val[1] = qual_b;
  assign q_thr[0] = qa_thr;
  assign q_thr[1] = qb_thr;

  // one comparator per quality measure
  for (genvar g = 0; g < NQ; g++) begin : g_qcmp
    assign q_meet[g] = (q_val[g] >= q_thr[g]);
  end

  always_comb begin
    ed_flag = (rssi_smp > ed_thr);
    cs_flag = &q_meet;
  end

  // held strength for host read-back, clock-enabled by the sample strobe
  always_comb begin
    rssi_d = rssi_q;
    if (smp_vld) rssi_d = rssi_smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rssi_q <= '0;
    else        rssi_q <= rssi_d;
  end

  // R10
  rssi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(rssi_q));

endmodule

// File: rtl/cca_timeout.sv
module cca_timeout #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  input  logic [CW-1:0] m_lim,
  input  logic [CW-1:0] n_lim,
  output logic          at_end
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] m_eff, n_eff;
  logic [CW-1:0] inner_q, inner_d;
  logic [CW-1:0] outer_q, outer_d;
  logic          inner_last, outer_last;

  always_comb begin
    m_eff      = (m_lim == '0) ? ONE : m_lim;
    n_eff      = (n_lim == '0) ? ONE : n_lim;
    inner_last = (inner_q >= m_eff - ONE);
    outer_last = (outer_q >= n_eff - ONE);
    at_end     = inner_last && outer_last;
  end

  always_comb begin
    inner_d = inner_q;
    outer_d = outer_q;
    if (clr || (adv && at_end)) begin
      inner_d = '0;
      outer_d = '0;
    end else if (adv) begin
      if (inner_last) begin
        inner_d = '0;
        outer_d = outer_q + ONE;
      end else begin
        inner_d = inner_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner_q <= '0;
      outer_q <= '0;
    end else begin
      inner_q <= inner_d;
      outer_q <= outer_d;
    end
  end

  // R5
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (inner_q == '0) && (outer_q == '0));

  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(inner_q) && $stable(outer_q));

endmodule

// File: rtl/cca_fsm.sv
module cca_fsm
  import cca_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic ed_flag,
  input  logic cs_flag,
  input  logic at_end,
  input  logic pol_low,
  output logic cnt_adv,
  output logic cnt_clr,
  output logic cca_out
);

  cca_st_e st_q, st_d;
  logic    ed_only;

  always_comb begin
    ed_only = ed_flag && !cs_flag;
    cnt_adv = smp_vld && ed_only && (st_q != ST_EXP);
    cnt_clr = smp_vld && !ed_only;
  end

  always_comb begin
    st_d = st_q;
    if (smp_vld) begin
      if (cs_flag)       st_d = ST_CS;
      else if (!ed_flag) st_d = ST_CLEAR;
      else if (st_q == ST_EXP) st_d = ST_EXP;
      else if (at_end)   st_d = ST_EXP;
      else               st_d = ST_ED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_CLEAR;
    else        st_q <= st_d;
  end

  assign cca_out = st_is_clear(st_q) ^ pol_low;

  // R5
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cs_flag) |=> (st_q == ST_CS));

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !cs_flag && !ed_flag) |=> (st_q == ST_CLEAR));

  // R10
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(st_q));

  // R7
  exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && ed_flag && !cs_flag && (st_q == ST_EXP)) |=> (st_q == ST_EXP));

endmodule

// File: rtl/cca_ctrl.sv
module cca_ctrl #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] rssi_smp,
  input  logic [DW-1:0] qual_a,
  input  logic [DW-1:0] qual_b,
  input  logic [DW-1:0] ed_thr,
  input  logic [DW-1:0] qa_thr,
  input  logic [DW-1:0] qb_thr,
  input  logic [CW-1:0] inner_lim,
  input  logic [CW-1:0] outer_lim,
  input  logic          pol_low,
  output logic          cca_out,
  output logic [DW-1:0] rssi_rd
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   ed_flag, cs_flag;
  logic                   cnt_adv, cnt_clr, at_end;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  cca_detect #(.DW(DW)) u_det (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .smp_vld  (smp_vld),
    .rssi_smp (rssi_smp),
    .qual_a   (qual_a),
    .qual_b   (qual_b),
    .ed_thr   (ed_thr),
    .qa_thr   (qa_thr),
    .qb_thr   (qb_thr),
    .ed_flag  (ed_flag),
    .cs_flag  (cs_flag),
    .rssi_q   (rssi_rd)
  );

  cca_timeout #(.CW(CW)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv    (cnt_adv),
    .clr    (cnt_clr),
    .m_lim  (inner_lim),
    .n_lim  (outer_lim),
    .at_end (at_end)
  );

  cca_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .smp_vld (smp_vld),
    .ed_flag (ed_flag),
    .cs_flag (cs_flag),
    .at_end  (at_end),
    .pol_low (pol_low),
    .cnt_adv (cnt_adv),
    .cnt_clr (cnt_clr),
    .cca_out (cca_out)
  );

endmodule

// File: tb/sim_cca_ctrl.sv
module sim_cca_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_vld;
  logic [7:0] rssi_smp, qual_a, qual_b, ed_thr, qa_thr, qb_thr;
  logic [7:0] inner_lim, outer_lim;
  logic       pol_low;
  logic       cca_out;
  logic [7:0] rssi_rd;

  int n_cmp = 0;
  int n_bad = 0;
  // model state: 0 clear, 1 carrier, 2 energy counting, 3 expired
  int m_st = 0;
  int m_k  = 0;
  logic [7:0] m_rssi = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cca_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .rssi_smp(rssi_smp),
    .qual_a(qual_a), .qual_b(qual_b), .ed_thr(ed_thr), .qa_thr(qa_thr),
    .qb_thr(qb_thr), .inner_lim(inner_lim), .outer_lim(outer_lim),
    .pol_low(pol_low), .cca_out(cca_out), .rssi_rd(rssi_rd)
  );

  function automatic int eff(logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  function automatic logic exp_out(int st, logic pl);
    return ((st == 0) || (st == 3)) ^ pl;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance the model by one valid sample (R2..R8)
  task automatic model_step();
    logic ed, cs;
    ed = rssi_smp > ed_thr;
    cs = (qual_a >= qa_thr) && (qual_b >= qb_thr);
    m_rssi = rssi_smp;
    if (cs) begin m_st = 1; m_k = 0; end
    else if (!ed) begin m_st = 0; m_k = 0; end
    else if (m_st == 3) m_k = 0;
    else begin
      m_k++;
      if (m_k >= eff(inner_lim) * eff(outer_lim)) begin m_st = 3; m_k = 0; end
      else m_st = 2;
    end
  endtask

  // drive one cycle from a negedge, check after the rising edge
  task automatic cyc(logic v, logic [7:0] r, logic [7:0] a, logic [7:0] b, string req);
    @(negedge clk);
    smp_vld = v; rssi_smp = r; qual_a = a; qual_b = b;
    @(posedge clk);
    #1;
    if (v) model_step();
    chk(req, int'(cca_out), int'(exp_out(m_st, pol_low)));
    chk(req, int'(rssi_rd), int'(m_rssi));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd20240611));
    rst_n = 1'b0; smp_vld = 1'b0; rssi_smp = '0; qual_a = '0; qual_b = '0;
    ed_thr = 8'd100; qa_thr = 8'd50; qb_thr = 8'd60;
    inner_lim = 8'd3; outer_lim = 8'd2; pol_low = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", int'(cca_out), 1);
    chk("R1", int'(rssi_rd), 0);

    // R6: M=3,N=2 -> five busy, sixth clear
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 8'd150, 8'd0, 8'd0, "R6");
      chk("R6", int'(cca_out), 0);
    end
    cyc(1'b1, 8'd150, 8'd0, 8'd0, "R6");
    chk("R6", int'(cca_out), 1);
    // R7 stays clear under energy-only
    for (int i = 0; i < 8; i++) cyc(1'b1, 8'd160, 8'd0, 8'd0, "R7");
    chk("R7", int'(cca_out), 1);
    // R5 carrier gives busy
    cyc(1'b1, 8'd150, 8'd50, 8'd60, "R5");
    chk("R5", int'(cca_out), 0);
    // R3 only one quality met -> no carrier, energy-only count restarts
    cyc(1'b1, 8'd150, 8'd50, 8'd59, "R3");
    chk("R3", int'(cca_out), 0);
    // R2 equal strength is not energy -> clear
    cyc(1'b1, 8'd100, 8'd0, 8'd0, "R2");
    chk("R2", int'(cca_out), 1);
    // R4 idle sample resets the count: need full six again
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'd101, 8'd0, 8'd0, "R4");
    cyc(1'b1, 8'd20, 8'd0, 8'd0, "R4");
    chk("R4", int'(cca_out), 1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'd101, 8'd0, 8'd0, "R4");
    chk("R4", int'(cca_out), 0);
    // R10 cycles without a sample: no change in output or read port
    for (int i = 0; i < 4; i++) cyc(1'b0, 8'd7, 8'd0, 8'd0, "R10");
    chk("R10", int'(rssi_rd), 101);
    cyc(1'b1, 8'd101, 8'd0, 8'd0, "R10");
    chk("R10", int'(cca_out), 1);
    // R11 output unchanged before the edge
    @(negedge clk);
    smp_vld = 1'b1; rssi_smp = 8'd5; qual_a = 8'd200; qual_b = 8'd200;
    #1;
    chk("R11", int'(cca_out), 1);
    chk("R11", int'(rssi_rd), 101);
    @(posedge clk); #1;
    model_step();
    chk("R11", int'(cca_out), 0);
    chk("R11", int'(rssi_rd), 5);
    // R9 polarity change within the cycle
    @(negedge clk);
    smp_vld = 1'b0; pol_low = 1'b1;
    #1;
    chk("R9", int'(cca_out), 1);
    pol_low = 1'b0;
    #1;
    chk("R9", int'(cca_out), 0);
    // R8 zero limits act as one: first energy-only sample clears
    cyc(1'b1, 8'd10, 8'd0, 8'd0, "R8");
    @(negedge clk); inner_lim = 8'd0; outer_lim = 8'd0;
    cyc(1'b1, 8'd200, 8'd0, 8'd0, "R8");
    chk("R8", int'(cca_out), 1);
    cyc(1'b1, 8'd10, 8'd0, 8'd0, "R8");
    @(negedge clk); inner_lim = 8'd0; outer_lim = 8'd3;
    cyc(1'b1, 8'd200, 8'd0, 8'd0, "R8");
    chk("R8", int'(cca_out), 0);
    cyc(1'b1, 8'd200, 8'd0, 8'd0, "R8");
    cyc(1'b1, 8'd200, 8'd0, 8'd0, "R8");
    chk("R8", int'(cca_out), 1);

    // random blocks: limits and polarity change after an idle sample
    for (int blk = 0; blk < 40; blk++) begin
      cyc(1'b1, 8'd0, 8'd0, 8'd0, "R4");
      @(negedge clk);
      inner_lim = 8'($urandom % 4);
      outer_lim = 8'($urandom % 4);
      pol_low   = 1'($urandom % 2);
      ed_thr    = 8'(90 + $urandom % 20);
      for (int i = 0; i < 200; i++) begin
        logic       v;
        logic [7:0] r, a, b;
        v = ($urandom % 8) != 0;
        r = 8'(int'(ed_thr) - 4 + int'($urandom % 16));
        a = (($urandom % 4) == 0) ? 8'(int'(qa_thr) + int'($urandom % 3))
                                  : 8'(int'(qa_thr) - 1 - int'($urandom % 5));
        b = (($urandom % 3) == 0) ? 8'(int'(qb_thr) + int'($urandom % 3))
                                  : 8'(int'(qb_thr) - 1 - int'($urandom % 5));
        cyc(v, r, a, b, "R6");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule